// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry Unit

This unit sits beside the execute stage of a 32-bit processor and decides, at each instruction boundary, whether a pending interrupt is taken. Four classes of request compete: a 4-bit encoded external level, a set of pin requests and a set of on-chip peripheral requests (each of these with a programmable 4-bit priority), and a debug-port request that always carries level 15. The unit picks one winner and compares its level against the interrupt mask in the current status word. It also checks the block bit.

When a request is taken, the unit registers everything the core needs to enter the handler in one step. It keeps the return address and a copy of the old status word, and it writes an event code twice: into the code register and into its copy. It also builds the new status word and the handler address, and it raises a one-cycle accept pulse together with a pipeline flush. The mask field in the new status word is left at its old value; it is not loaded with the level that was taken. The core applies `sr_o` and redirects fetch to `new_pc_o` on the accept pulse.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A request is taken only when the block bit (status bit 28) is 0 and the winning level is strictly greater than the mask field (status bits 7:4); otherwise nothing is taken.
- R2: A request is taken only in a cycle where `boundary_i` is high. The accept is visible on `accept_o` for exactly the one cycle after that clock edge.
- R3: On acceptance `spc_o` takes `next_pc_i` and `ssr_o` takes the whole `sr_i` sampled in the boundary cycle.
- R4: An external level L (1..15; 0 means no request) gives event code 0x200 + L*0x20, written to both `intevt_o` and `intevt2_o`.
- R5: On acceptance `sr_o` equals `sr_i` with bits 30 (privileged mode), 29 (register bank) and 28 (block) set to 1. All other bits are kept, including the mask field 7:4.
- R6: On acceptance `new_pc_o` is `vbr_i` + 0x600, whatever the source class.
- R7: The debug request competes at level 15 and has event code 0x5E0. It is taken whenever the mask is below 15 and the block bit is 0.
- R8: Pin request i has event code 0x600 + i*0x20. Peripheral request j has event code 0x400 + j*0x20. Each competes at its own 4-bit priority field, taken from bits 4i+3:4i of the matching priority vector.
- R9: The highest level wins. Among equal levels the order is: debug first, then external, then pins by rising index, then peripherals by rising index.
- R10: After reset `spc_o`, `ssr_o`, `intevt_o`, `intevt2_o` and `new_pc_o` are 0, `accept_o` and `flush_o` are 0, and `sr_o` is 0x100000F0 (block bit set, mask 15).
- R11: In a cycle where nothing is taken, `spc_o`, `ssr_o`, `intevt_o`, `intevt2_o`, `sr_o` and `new_pc_o` keep their values.
- R12: `flush_o` is high in exactly the cycles where `accept_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| ext_level_i | input | 4 | Encoded external level, 0 = none |
| pin_req_i | input | N_PIN | Pin request lines |
| pin_prio_i | input | N_PIN*4 | Pin priorities, 4 bits per pin |
| per_req_i | input | N_PER | Peripheral request lines |
| per_prio_i | input | N_PER*4 | Peripheral priorities, 4 bits each |
| dbg_req_i | input | 1 | Debug-port interrupt request |
| sr_i | input | 32 | Current status word |
| next_pc_i | input | 32 | Address of the instruction after the boundary |
| vbr_i | input | 32 | Vector base |
| accept_o | output | 1 | One-cycle acceptance pulse |
| flush_o | output | 1 | Pipeline flush request |
| new_pc_o | output | 32 | Handler fetch address |
| spc_o | output | 32 | Saved return address |
| ssr_o | output | 32 | Saved status word |
| intevt_o | output | 12 | Event code |
| intevt2_o | output | 12 | Event code copy |
| sr_o | output | 32 | Status word to apply on entry |

## Verification
The hardest case to reach is a tie at the same level between several classes at once, for example the debug request against external level 15, or two pins and a peripheral at one priority. Other situations along the way can hide a wrong tie order, because the wrong winner may simply be blocked by the mask. The directed stimulus drives each tie with the mask set low, so that the tie order alone decides the event code. A long random phase then mixes sparse requests, random masks, a set block bit and missing boundary strobes, and checks every one against an ordered reference model.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int LVL_W   = 4;
  localparam int CODE_W  = 12;
  localparam int SR_MD   = 30;
  localparam int SR_RB   = 29;
  localparam int SR_BL   = 28;
  localparam int SR_M_LO = 4;
  localparam int SR_M_HI = SR_M_LO + LVL_W - 1;

  localparam logic [31:0] SR_ENTRY_SET = (32'd1 << SR_MD) | (32'd1 << SR_RB) | (32'd1 << SR_BL);
  localparam logic [31:0] SR_RESET     = (32'd1 << SR_BL) | (32'hF << SR_M_LO);

  localparam logic [CODE_W-1:0] CODE_EXT_BASE = 12'h200;
  localparam logic [CODE_W-1:0] CODE_DBG      = 12'h5E0;
  localparam logic [CODE_W-1:0] CODE_STEP     = 12'h020;

  typedef struct packed {
    logic              vld;
    logic [LVL_W-1:0]  lvl;
    logic [CODE_W-1:0] code;
  } irq_cand_t;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_entry_pkg::*;
#(
  parameter int N_PIN = 4,
  parameter int N_PER = 8,
  parameter logic [CODE_W-1:0] PIN_BASE = 12'h600,
  parameter logic [CODE_W-1:0] PER_BASE = 12'h400
) (
  input  logic [LVL_W-1:0]       ext_level_i,
  input  logic                   dbg_req_i,
  input  logic [N_PIN-1:0]       pin_req_i,
  input  logic [N_PIN*LVL_W-1:0] pin_prio_i,
  input  logic [N_PER-1:0]       per_req_i,
  input  logic [N_PER*LVL_W-1:0] per_prio_i,
  output irq_cand_t              win_o
);
  localparam int N_CAND  = 2 + N_PIN + N_PER;
  localparam int PIN_OFS = 2;
  localparam int PER_OFS = 2 + N_PIN;

  irq_cand_t cand [N_CAND];

  // Candidate order is the tie order: debug, external, pins, peripherals.
  assign cand[0] = '{vld: dbg_req_i, lvl: {LVL_W{1'b1}}, code: CODE_DBG};
  assign cand[1] = '{vld: |ext_level_i, lvl: ext_level_i,
                     code: CODE_EXT_BASE + CODE_W'(ext_level_i) * CODE_STEP};

  genvar gi;
  generate
    for (gi = 0; gi < N_PIN; gi++) begin : g_pin
      localparam logic [CODE_W-1:0] PCODE = CODE_W'(PIN_BASE + gi * 32);
      assign cand[PIN_OFS+gi] = '{vld: pin_req_i[gi],
                                  lvl: pin_prio_i[gi*LVL_W +: LVL_W],
                                  code: PCODE};
    end
    for (gi = 0; gi < N_PER; gi++) begin : g_per
      localparam logic [CODE_W-1:0] QCODE = CODE_W'(PER_BASE + gi * 32);
      assign cand[PER_OFS+gi] = '{vld: per_req_i[gi],
                                  lvl: per_prio_i[gi*LVL_W +: LVL_W],
                                  code: QCODE};
    end
  endgenerate

  // Earlier candidates keep the slot unless a later one is strictly higher.
  always_comb begin
    win_o = '0;
    for (int k = 0; k < N_CAND; k++) begin
      if (cand[k].vld && (!win_o.vld || (cand[k].lvl > win_o.lvl))) begin
        win_o = cand[k];
      end
    end
  end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_entry_pkg::*;
(
  input  logic      boundary_i,
  input  irq_cand_t win_i,
  input  logic [31:0] sr_i,
  output logic      take_o
);
  logic             blocked;
  logic [LVL_W-1:0] mask;

  always_comb begin
    blocked = sr_i[SR_BL];
    mask    = sr_i[SR_M_HI:SR_M_LO];
    take_o  = boundary_i && win_i.vld && !blocked && (win_i.lvl > mask);
  end
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_entry_pkg::*;
#(
  parameter logic [31:0] VEC_OFS = 32'h600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [31:0]       sr_i,
  input  logic [31:0]       next_pc_i,
  input  logic [31:0]       vbr_i,
  output logic              accept_o,
  output logic              flush_o,
  output logic [31:0]       new_pc_o,
  output logic [31:0]       spc_o,
  output logic [31:0]       ssr_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [CODE_W-1:0] intevt2_o,
  output logic [31:0]       sr_o
);
  logic              acc_q, acc_d;
  logic [31:0]       pc_q, pc_d, spc_q, spc_d, ssr_q, ssr_d, sr_q, sr_d;
  logic [CODE_W-1:0] ev_q, ev_d, ev2_q, ev2_d;

  always_comb begin
    acc_d = take_i;
    pc_d  = pc_q;
    spc_d = spc_q;
    ssr_d = ssr_q;
    sr_d  = sr_q;
    ev_d  = ev_q;
    ev2_d = ev2_q;
    if (take_i) begin
      pc_d  = vbr_i + VEC_OFS;
      spc_d = next_pc_i;
      ssr_d = sr_i;
      sr_d  = sr_i | SR_ENTRY_SET;
      ev_d  = code_i;
      ev2_d = code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      pc_q  <= '0;
      spc_q <= '0;
      ssr_q <= '0;
      sr_q  <= SR_RESET;
      ev_q  <= '0;
      ev2_q <= '0;
    end else begin
      acc_q <= acc_d;
      pc_q  <= pc_d;
      spc_q <= spc_d;
      ssr_q <= ssr_d;
      sr_q  <= sr_d;
      ev_q  <= ev_d;
      ev2_q <= ev2_d;
    end
  end

  assign accept_o  = acc_q;
  assign flush_o   = acc_q;
  assign new_pc_o  = pc_q;
  assign spc_o     = spc_q;
  assign ssr_o     = ssr_q;
  assign sr_o      = sr_q;
  assign intevt_o  = ev_q;
  assign intevt2_o = ev2_q;
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int N_PIN = 4,
  parameter int N_PER = 8,
  parameter logic [CODE_W-1:0] PIN_BASE = 12'h600,
  parameter logic [CODE_W-1:0] PER_BASE = 12'h400,
  parameter logic [31:0] VEC_OFS = 32'h600
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boundary_i,
  input  logic [LVL_W-1:0]       ext_level_i,
  input  logic [N_PIN-1:0]       pin_req_i,
  input  logic [N_PIN*LVL_W-1:0] pin_prio_i,
  input  logic [N_PER-1:0]       per_req_i,
  input  logic [N_PER*LVL_W-1:0] per_prio_i,
  input  logic                   dbg_req_i,
  input  logic [31:0]            sr_i,
  input  logic [31:0]            next_pc_i,
  input  logic [31:0]            vbr_i,
  output logic                   accept_o,
  output logic                   flush_o,
  output logic [31:0]            new_pc_o,
  output logic [31:0]            spc_o,
  output logic [31:0]            ssr_o,
  output logic [CODE_W-1:0]      intevt_o,
  output logic [CODE_W-1:0]      intevt2_o,
  output logic [31:0]            sr_o
);
  irq_cand_t win;
  logic      take;

  irq_prio_arb #(
    .N_PIN(N_PIN), .N_PER(N_PER), .PIN_BASE(PIN_BASE), .PER_BASE(PER_BASE)
  ) arb_i (
    .ext_level_i(ext_level_i), .dbg_req_i(dbg_req_i),
    .pin_req_i(pin_req_i), .pin_prio_i(pin_prio_i),
    .per_req_i(per_req_i), .per_prio_i(per_prio_i),
    .win_o(win)
  );

  irq_accept_gate gate_i (
    .boundary_i(boundary_i), .win_i(win), .sr_i(sr_i), .take_o(take)
  );

  irq_entry_regs #(.VEC_OFS(VEC_OFS)) regs_i (
    .clk(clk), .rst_n(rst_n), .take_i(take), .code_i(win.code),
    .sr_i(sr_i), .next_pc_i(next_pc_i), .vbr_i(vbr_i),
    .accept_o(accept_o), .flush_o(flush_o), .new_pc_o(new_pc_o),
    .spc_o(spc_o), .ssr_o(ssr_o), .intevt_o(intevt_o),
    .intevt2_o(intevt2_o), .sr_o(sr_o)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
#(
  parameter logic [31:0] VEC_OFS = 32'h600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic [31:0]       sr_i,
  input logic [31:0]       next_pc_i,
  input logic [31:0]       vbr_i,
  input logic              accept_o,
  input logic [31:0]       new_pc_o,
  input logic [31:0]       spc_o,
  input logic [31:0]       ssr_o,
  input logic [31:0]       sr_o
);
  a_r2_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> $past(boundary_i));

  a_r1_block_bit_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> !$past(sr_i[SR_BL]));

  a_r3_saved_context: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (spc_o == $past(next_pc_i)) && (ssr_o == $past(sr_i)));

  a_r5_status_update: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (sr_o[SR_MD] && sr_o[SR_RB] && sr_o[SR_BL] &&
                  sr_o[SR_M_HI:SR_M_LO] == $past(sr_i[SR_M_HI:SR_M_LO])));

  a_r6_handler_address: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> new_pc_o == $past(vbr_i) + VEC_OFS);

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_o |-> ($stable(spc_o) && $stable(ssr_o) && $stable(sr_o) && $stable(new_pc_o)));
endmodule

bind irq_entry_ctrl irq_entry_chk #(.VEC_OFS(VEC_OFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .sr_i(sr_i),
  .next_pc_i(next_pc_i), .vbr_i(vbr_i), .accept_o(accept_o),
  .new_pc_o(new_pc_o), .spc_o(spc_o), .ssr_o(ssr_o), .sr_o(sr_o)
);

// File: tb/irq_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb_top;
  localparam int NP = 4;
  localparam int NQ = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0;
  logic [3:0] ext_level = '0;
  logic [NP-1:0] pin_req = '0;
  logic [NP*4-1:0] pin_prio = '0;
  logic [NQ-1:0] per_req = '0;
  logic [NQ*4-1:0] per_prio = '0;
  logic dbg_req = 1'b0;
  logic [31:0] sr = '0, npc = '0, vbr = '0;
  logic accept, flush;
  logic [31:0] new_pc, spc, ssr, sr_out;
  logic [11:0] ev, ev2;

  always #5 clk = ~clk;

  irq_entry_ctrl #(.N_PIN(NP), .N_PER(NQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .ext_level_i(ext_level),
    .pin_req_i(pin_req), .pin_prio_i(pin_prio), .per_req_i(per_req),
    .per_prio_i(per_prio), .dbg_req_i(dbg_req), .sr_i(sr), .next_pc_i(npc),
    .vbr_i(vbr), .accept_o(accept), .flush_o(flush), .new_pc_o(new_pc),
    .spc_o(spc), .ssr_o(ssr), .intevt_o(ev), .intevt2_o(ev2), .sr_o(sr_out)
  );

  typedef struct {
    bit          take;
    logic [31:0] spc, ssr, sr, pc;
    logic [11:0] code;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [31:0] m_spc = 0, m_ssr = 0, m_sr = 32'h100000F0, m_pc = 0;
  logic [11:0] m_code = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit bnd, input logic [3:0] ext, input bit dbg,
                       input logic [NP-1:0] preq, input logic [NP*4-1:0] ppr,
                       input logic [NQ-1:0] qreq, input logic [NQ*4-1:0] qpr,
                       input logic [31:0] s, input logic [31:0] pc,
                       input logic [31:0] vb, input string tag);
    bit vld;
    logic [3:0] lvl;
    logic [11:0] code;
    exp_t e;
    @(negedge clk);
    boundary = bnd; ext_level = ext; dbg_req = dbg; pin_req = preq;
    pin_prio = ppr; per_req = qreq; per_prio = qpr; sr = s; npc = pc; vbr = vb;
    vld = 0; lvl = 0; code = 0;
    if (dbg) begin vld = 1; lvl = 15; code = 12'h5E0; end
    if (ext != 0 && (!vld || ext > lvl)) begin vld = 1; lvl = ext; code = 12'h200 + 12'(ext) * 12'h20; end
    for (int i = 0; i < NP; i++)
      if (preq[i] && (!vld || ppr[i*4 +: 4] > lvl)) begin
        vld = 1; lvl = ppr[i*4 +: 4]; code = 12'(12'h600 + i * 32);
      end
    for (int j = 0; j < NQ; j++)
      if (qreq[j] && (!vld || qpr[j*4 +: 4] > lvl)) begin
        vld = 1; lvl = qpr[j*4 +: 4]; code = 12'(12'h400 + j * 32);
      end
    e.take = bnd && vld && !s[28] && (lvl > s[7:4]);
    if (e.take) begin
      m_spc = pc; m_ssr = s; m_sr = s | 32'h7000_0000; m_pc = vb + 32'h600; m_code = code;
    end
    e.spc = m_spc; e.ssr = m_ssr; e.sr = m_sr; e.pc = m_pc; e.code = m_code; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    boundary = 0;
  endtask

  // Monitor: compares just after each rising edge against the queued item.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(accept == e.take, e.tag, "accept", 32'(accept), 32'(e.take));
      check(flush == accept, "R12", "flush", 32'(flush), 32'(accept));
      check(spc == e.spc && ssr == e.ssr, e.take ? "R3" : "R11", "spc/ssr",
            e.take ? spc : ssr, e.take ? e.spc : e.ssr);
      check(ev == e.code && ev2 == e.code, e.tag, "event code", {ev2, 8'h0, ev}, 32'(e.code));
      check(sr_out == e.sr, e.take ? "R5" : "R11", "status", sr_out, e.sr);
      check(new_pc == e.pc, e.take ? "R6" : "R11", "handler pc", new_pc, e.pc);
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!accept && !flush, "R10", "accept/flush", 32'(accept), 0);
    check(spc == 0 && ssr == 0 && new_pc == 0, "R10", "saved regs", spc | ssr | new_pc, 0);
    check(ev == 0 && ev2 == 0, "R10", "event code", 32'(ev), 0);
    check(sr_out == 32'h100000F0, "R10", "status", sr_out, 32'h100000F0);

    // R4 external level 5 above mask 3
    drive(1, 4'd5, 0, 0, 0, 0, 0, 32'h0000_0030, 32'h1000, 32'h8000_0000, "R4");
    // R1 equal level is refused
    drive(1, 4'd3, 0, 0, 0, 0, 0, 32'h0000_0030, 32'h2000, 32'h8000_0000, "R1");
    // R1 block bit refuses even level 15
    drive(1, 4'd15, 0, 0, 0, 0, 0, 32'h1000_0000, 32'h2004, 32'h8000_0000, "R1");
    // R2 no boundary, no acceptance
    drive(0, 4'd15, 1, 0, 0, 0, 0, 32'h0, 32'h2008, 32'h8000_0000, "R2");
    // R7/R9 debug beats external level 15 on a tie
    drive(1, 4'd15, 1, 0, 0, 0, 0, 32'h0000_0012, 32'h3000, 32'h4000_0000, "R7");
    // R7 accepted at mask 14, refused at mask 15
    drive(1, 4'd0, 1, 0, 0, 0, 0, 32'h0000_00E0, 32'h3100, 32'h4000_1000, "R7");
    drive(1, 4'd0, 1, 0, 0, 0, 0, 32'h0000_00F0, 32'h3200, 32'h4000_2000, "R7");
    // R8 peripheral 0 at 12 beats pins at 9
    drive(1, 4'd0, 0, 4'b0110, 16'h0990, 8'h01, 32'h0000_000C, 32'h0, 32'h3300, 32'h0, "R8");
    // R9 pin tie: lower index wins
    drive(1, 4'd0, 0, 4'b0110, 16'h0990, 8'h00, 32'h0, 32'h0, 32'h3400, 32'h0, "R9");
    // R9 external beats pin 0 at equal level 7
    drive(1, 4'd7, 0, 4'b0001, 16'h0007, 8'h00, 32'h0, 32'h0, 32'h3500, 32'h0, "R9");
    // R9 peripheral tie: index 3 over index 5
    drive(1, 4'd0, 0, 0, 0, 8'b0010_1000, 32'h0040_4000, 32'h0, 32'h3600, 32'h0, "R9");
    // R8 peripheral 7 highest code
    drive(1, 4'd0, 0, 0, 0, 8'h80, 32'h2000_0000, 32'h0, 32'h3700, 32'h0, "R8");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] s;
      s = $urandom;
      s[28] = ($urandom % 8) == 0;
      drive(($urandom % 4) != 0, ($urandom % 3 == 0) ? 4'($urandom) : 4'd0,
            ($urandom % 10) == 0, 4'($urandom & $urandom), 16'($urandom),
            8'($urandom & $urandom & $urandom), $urandom, s, $urandom, $urandom, "R9");
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule